// File: doc/BRIEF.md
# Load-Use Pipeline Interlock Unit

This unit sits beside the Decode stage of a five-stage in-order pipeline (Fetch, Decode, Execute, Memory, Write). Each cycle it takes the descriptor of the instruction in Decode and compares it with the loads that are still on their way through Execute and Memory. The descriptor gives the register read on each of the three read ports (A, B and C) with a use flag for each, whether the instruction is a single load, the load's size and destination, and whether it is a load/store-multiple with its base register and the first register it stores. The unit holds Decode, or Execute when a store-multiple is in Execute, and asks for a bubble in the stage after the one held.

The cost of a hazard depends on the consumer's port and on the load size. Full-word loads reach the A and B forwarding paths one cycle sooner than byte and halfword loads, which still need alignment and sign or zero extension. The C port has no forwarding path. It serves store data for single and multiple stores and the accumulate operand of multiply-accumulate, so it can only read loaded data once the load has reached Write. Store-multiple reads its first stored register in its first Execute cycle, so it can be held a second time, in Execute. A multi-cycle instruction already holding Execute covers the load latency. A flush cancels every interlock in its cycle.

Top module: `lu_interlock`

## Requirements
- R1: After a synchronous active-low reset no load is tracked, and no descriptor in Decode causes any stall or bubble.
- R2: A full-word load (size code 2'b10) whose destination is read on the A or B port by the next instruction holds that instruction in Decode for exactly one cycle.
- R3: A byte (2'b00) or halfword (2'b01) load holds an immediately following A/B consumer for two cycles, and one for one cycle when a single independent instruction sits between them. Code 2'b11 counts as narrow.
- R4: Once a consumer has waited out its stall, a later instruction reading the same loaded register is not held.
- R5: A C-port consumer directly after a load of any size is held for one cycle. With one independent instruction between them it is not held.
- R6: While ex_hold_i is high (a multi-cycle instruction occupies Execute), the unit raises no Decode stall of its own, and a consumer placed after a two-cycle instruction that follows a byte load is never held.
- R7: A load/store-multiple whose base register is the destination of a pending load is held in Decode under the A/B rule: one cycle after a word load, two after a narrow load.
- R8: A store-multiple whose first stored register is a load destination still within two cycles of that load entering Execute is held in Execute for one cycle, and Decode is held with it.
- R9: bubble_ex_o is high exactly when Decode is held while Execute is not. bubble_mem_o is high exactly when Execute is held.
- R10: In a flush cycle all stall and bubble outputs are low. The instruction in Decode is not taken, so a load flushed there is never tracked. A store-multiple in Execute is dropped.
- R11: A register index whose use flag is low, or a pending load whose destination matches no used port, causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid_i | input | 1 | A real instruction is in Decode |
| dec_ra_i | input | REG_W | Register on read port A |
| dec_ra_use_i | input | 1 | Port A is read |
| dec_rb_i | input | REG_W | Register on read port B |
| dec_rb_use_i | input | 1 | Port B is read |
| dec_rc_i | input | REG_W | Register on read port C (store data or accumulate) |
| dec_rc_use_i | input | 1 | Port C is read |
| dec_is_load_i | input | 1 | Instruction is a single load |
| dec_ld_size_i | input | 2 | Load size: 00 byte, 01 halfword, 10 word |
| dec_ld_dst_i | input | REG_W | Load destination register |
| dec_is_multi_i | input | 1 | Instruction is a load/store-multiple |
| dec_is_stm_i | input | 1 | The multiple transfer is a store |
| dec_base_i | input | REG_W | Base register of the multiple transfer |
| dec_first_i | input | REG_W | First register stored by a store-multiple |
| ex_hold_i | input | 1 | Execute is occupied by a multi-cycle instruction |
| flush_i | input | 1 | Pipeline flush this cycle |
| stall_dec_o | output | 1 | Hold Decode and earlier stages |
| stall_ex_o | output | 1 | Hold Execute and earlier stages |
| bubble_ex_o | output | 1 | Insert an empty slot into Execute |
| bubble_mem_o | output | 1 | Insert an empty slot into Memory |

## Verification
The bench places the consumer at distance one and two from loads of each size and counts the cycles it waits. A design that treated all sizes alike would show one cycle where two are due, and one that forwarded to the C port would show no stall for a store right after a load. It follows a stalled consumer with a second reader of the same register, which a design that forgot to age its loads would hold again, and it puts a store-multiple behind a word load so that only the first stored register collides. Missing the Execute hold there lets the store read stale data with no stall. Flush and multi-cycle-hold cycles go in with a hazard present, and a design that ignored them would raise a stall or track a load that was cancelled.

// File: rtl/lu_pkg.sv
// Package lu_pkg
// Shared encodings for the load-use interlock unit.
// Assumes load sizes arrive as a two-bit code from Decode.
package lu_pkg;

    typedef enum logic [1:0] {
        LU_SZ_BYTE = 2'b00,
        LU_SZ_HALF = 2'b01,
        LU_SZ_WORD = 2'b10
    } lu_size_e;

    // Anything except a full word needs the alignment/extension step.
    function automatic logic lu_is_narrow(input logic [1:0] size);
        return size != LU_SZ_WORD;
    endfunction

    // Largest of four gap values, used to size the load tracker.
    function automatic int lu_max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lu_load_tracker.sv
// Module lu_load_tracker
// Age-indexed record of loads that have left Decode. Slot k holds the load
// that entered Execute k cycles ago. Loads never stall once past Decode, so
// every slot shifts by one position each cycle.
// Assumes push_i is high only in a cycle where a load leaves Decode.
module lu_load_tracker #(
    parameter int REG_W = 4,
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [REG_W-1:0]             rd_i,
    input  logic                         narrow_i,
    output logic [DEPTH-1:0]             vld_o,
    output logic [DEPTH-1:0][REG_W-1:0]  rd_o,
    output logic [DEPTH-1:0]             nar_o
);

    logic [DEPTH-1:0]            vld_q;
    logic [DEPTH-1:0][REG_W-1:0] rd_q;
    logic [DEPTH-1:0]            nar_q;

    // Age every tracked load by one slot and enter the new one at age zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            rd_q  <= '0;
            nar_q <= '0;
        end else begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                vld_q[i] <= vld_q[i-1];
                rd_q[i]  <= rd_q[i-1];
                nar_q[i] <= nar_q[i-1];
            end
            vld_q[0] <= push_i;
            rd_q[0]  <= rd_i;
            nar_q[0] <= narrow_i;
        end
    end

    assign vld_o = vld_q;
    assign rd_o  = rd_q;
    assign nar_o = nar_q;

endmodule

// File: rtl/lu_slot_check.sv
// Module lu_slot_check
// Hazard test for one tracker slot of fixed age AGE. It decides whether the
// Decode descriptor or the store-multiple in Execute must wait for this load.
// Assumes each gap is counted in cycles after the load enters Execute.
module lu_slot_check #(
    parameter int REG_W         = 4,
    parameter int AGE           = 0,
    parameter int WORD_AB_GAP   = 1,
    parameter int NARROW_AB_GAP = 2,
    parameter int C_PORT_GAP    = 1,
    parameter int STM_EX_GAP    = 2
) (
    input  logic             slot_vld_i,
    input  logic [REG_W-1:0] slot_rd_i,
    input  logic             slot_nar_i,
    input  logic             dec_valid_i,
    input  logic [REG_W-1:0] ra_i,
    input  logic             ra_use_i,
    input  logic [REG_W-1:0] rb_i,
    input  logic             rb_use_i,
    input  logic [REG_W-1:0] rc_i,
    input  logic             rc_use_i,
    input  logic             multi_i,
    input  logic [REG_W-1:0] base_i,
    input  logic             stm_vld_i,
    input  logic [REG_W-1:0] stm_first_i,
    output logic             dec_hit_o,
    output logic             ex_hit_o
);

    localparam bit WORD_BLK   = (AGE < WORD_AB_GAP);
    localparam bit NARROW_BLK = (AGE < NARROW_AB_GAP);
    localparam bit C_BLK      = (AGE < C_PORT_GAP);
    localparam bit EX_BLK     = (AGE < STM_EX_GAP);

    logic ab_blk;
    logic hit_a, hit_b, hit_c, hit_base;

    // Decide which port classes this slot still blocks and match them.
    always_comb begin
        ab_blk    = slot_nar_i ? NARROW_BLK : WORD_BLK;
        hit_a     = ra_use_i && (ra_i == slot_rd_i) && ab_blk;
        hit_b     = rb_use_i && (rb_i == slot_rd_i) && ab_blk;
        hit_c     = rc_use_i && (rc_i == slot_rd_i) && C_BLK;
        hit_base  = multi_i  && (base_i == slot_rd_i) && ab_blk;
        dec_hit_o = slot_vld_i && dec_valid_i && (hit_a || hit_b || hit_c || hit_base);
        ex_hit_o  = slot_vld_i && stm_vld_i && (stm_first_i == slot_rd_i) && EX_BLK;
    end

endmodule

// File: rtl/lu_stm_exec.sv
// Module lu_stm_exec
// Remembers a store-multiple in Execute and its first stored register, so
// that the C-port read of that register in Execute can be interlocked.
// Assumes take_i and keep_i are never high in the same cycle.
module lu_stm_exec #(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [REG_W-1:0] first_i,
    input  logic             keep_i,
    input  logic             flush_i,
    output logic             vld_o,
    output logic [REG_W-1:0] first_o
);

    logic             vld_q;
    logic [REG_W-1:0] first_q;

    // Load, keep or drop the Execute-stage store-multiple record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            first_q <= '0;
        end else if (flush_i) begin
            vld_q   <= 1'b0;
        end else if (take_i) begin
            vld_q   <= 1'b1;
            first_q <= first_i;
        end else if (!keep_i) begin
            vld_q   <= 1'b0;
        end
    end

    assign vld_o   = vld_q;
    assign first_o = first_q;

endmodule

// File: rtl/lu_interlock.sv
// Module lu_interlock
// Load-use interlock for a five-stage in-order pipeline. It compares the
// Decode descriptor with loads still in Execute/Memory and produces Decode
// and Execute stalls plus the matching bubble requests.
// Assumes the stalled stage and everything before it hold their registers,
// and that ex_hold_i already holds Decode when high.
module lu_interlock #(
    parameter int REG_W         = 4,
    parameter int WORD_AB_GAP   = 1,
    parameter int NARROW_AB_GAP = 2,
    parameter int C_PORT_GAP    = 1,
    parameter int STM_EX_GAP    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid_i,
    input  logic [REG_W-1:0] dec_ra_i,
    input  logic             dec_ra_use_i,
    input  logic [REG_W-1:0] dec_rb_i,
    input  logic             dec_rb_use_i,
    input  logic [REG_W-1:0] dec_rc_i,
    input  logic             dec_rc_use_i,
    input  logic             dec_is_load_i,
    input  logic [1:0]       dec_ld_size_i,
    input  logic [REG_W-1:0] dec_ld_dst_i,
    input  logic             dec_is_multi_i,
    input  logic             dec_is_stm_i,
    input  logic [REG_W-1:0] dec_base_i,
    input  logic [REG_W-1:0] dec_first_i,
    input  logic             ex_hold_i,
    input  logic             flush_i,
    output logic             stall_dec_o,
    output logic             stall_ex_o,
    output logic             bubble_ex_o,
    output logic             bubble_mem_o
);

    import lu_pkg::*;

    localparam int DEPTH = lu_max4(WORD_AB_GAP, NARROW_AB_GAP, C_PORT_GAP, STM_EX_GAP);

    logic [DEPTH-1:0]            slot_vld;
    logic [DEPTH-1:0][REG_W-1:0] slot_rd;
    logic [DEPTH-1:0]            slot_nar;
    logic [DEPTH-1:0]            slot_dec_hit;
    logic [DEPTH-1:0]            slot_ex_hit;
    logic                        stm_vld;
    logic [REG_W-1:0]            stm_first;
    logic                        advance;
    logic                        push_load;
    logic                        take_stm;

    lu_load_tracker #(
        .REG_W (REG_W),
        .DEPTH (DEPTH)
    ) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_load),
        .rd_i     (dec_ld_dst_i),
        .narrow_i (lu_is_narrow(dec_ld_size_i)),
        .vld_o    (slot_vld),
        .rd_o     (slot_rd),
        .nar_o    (slot_nar)
    );

    // One comparator per tracked age.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        lu_slot_check #(
            .REG_W         (REG_W),
            .AGE           (s),
            .WORD_AB_GAP   (WORD_AB_GAP),
            .NARROW_AB_GAP (NARROW_AB_GAP),
            .C_PORT_GAP    (C_PORT_GAP),
            .STM_EX_GAP    (STM_EX_GAP)
        ) u_chk (
            .slot_vld_i  (slot_vld[s]),
            .slot_rd_i   (slot_rd[s]),
            .slot_nar_i  (slot_nar[s]),
            .dec_valid_i (dec_valid_i),
            .ra_i        (dec_ra_i),
            .ra_use_i    (dec_ra_use_i),
            .rb_i        (dec_rb_i),
            .rb_use_i    (dec_rb_use_i),
            .rc_i        (dec_rc_i),
            .rc_use_i    (dec_rc_use_i),
            .multi_i     (dec_is_multi_i),
            .base_i      (dec_base_i),
            .stm_vld_i   (stm_vld),
            .stm_first_i (stm_first),
            .dec_hit_o   (slot_dec_hit[s]),
            .ex_hit_o    (slot_ex_hit[s])
        );
    end

    lu_stm_exec #(
        .REG_W (REG_W)
    ) u_stm (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take_stm),
        .first_i (dec_first_i),
        .keep_i  (stall_ex_o || ex_hold_i),
        .flush_i (flush_i),
        .vld_o   (stm_vld),
        .first_o (stm_first)
    );

    // Combine slot hits into stalls, bubbles and the Decode advance strobe.
    always_comb begin
        stall_ex_o   = (|slot_ex_hit) && !flush_i;
        stall_dec_o  = (((|slot_dec_hit) && !ex_hold_i) || stall_ex_o) && !flush_i;
        bubble_ex_o  = stall_dec_o && !stall_ex_o;
        bubble_mem_o = stall_ex_o;
        advance      = dec_valid_i && !stall_dec_o && !ex_hold_i && !flush_i;
        push_load    = advance && dec_is_load_i;
        take_stm     = advance && dec_is_multi_i && dec_is_stm_i;
    end

    // R10
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !stall_dec_o && !stall_ex_o && !bubble_ex_o && !bubble_mem_o);

    // R6
    hold_no_dec_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_hold_i && !stall_ex_o |-> !stall_dec_o && !bubble_ex_o);

    // R3
    dec_stall_max_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(stall_dec_o) && stall_dec_o |=> !stall_dec_o);

    // R8
    ex_stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_ex_o |=> !stall_ex_o);

    // R9
    bubble_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bubble_ex_o && bubble_mem_o));

endmodule

// File: tb/lu_interlock_tb_top.sv
// Bench for lu_interlock: a behavioural model keeps a queue of loads stamped
// with the cycle they entered Execute and is compared with the outputs each cycle.
module lu_interlock_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       d_valid, ra_use, rb_use, rc_use, is_load, is_multi, is_stm, hold, flush;
    logic [3:0] ra, rb, rc, ld_dst, base, first;
    logic [1:0] ld_size;
    logic       sd, se, bx, bm;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    lu_interlock dut_i (
        .clk(clk), .rst_n(rst_n), .dec_valid_i(d_valid),
        .dec_ra_i(ra), .dec_ra_use_i(ra_use), .dec_rb_i(rb), .dec_rb_use_i(rb_use),
        .dec_rc_i(rc), .dec_rc_use_i(rc_use), .dec_is_load_i(is_load),
        .dec_ld_size_i(ld_size), .dec_ld_dst_i(ld_dst), .dec_is_multi_i(is_multi),
        .dec_is_stm_i(is_stm), .dec_base_i(base), .dec_first_i(first),
        .ex_hold_i(hold), .flush_i(flush),
        .stall_dec_o(sd), .stall_ex_o(se), .bubble_ex_o(bx), .bubble_mem_o(bm)
    );

    // ---------------- reference model ----------------
    typedef struct { int t; logic [3:0] rd; bit nar; } ld_rec_t;
    ld_rec_t ldq[$];
    int      cyc = 0;
    bit      m_stm = 0;
    logic [3:0] m_first = '0;
    bit      e_sd, e_se, e_bx, e_bm, last_adv;
    bit      seen_se, seen_bx;

    function automatic void model_eval();
        bit hz = 0, eh = 0;
        foreach (ldq[i]) begin
            int age = cyc - ldq[i].t;
            bit ab  = ldq[i].nar ? (age <= 1) : (age == 0);
            if (d_valid) begin
                if (ra_use && ra == ldq[i].rd && ab) hz = 1;
                if (rb_use && rb == ldq[i].rd && ab) hz = 1;
                if (rc_use && rc == ldq[i].rd && age == 0) hz = 1;
                if (is_multi && base == ldq[i].rd && ab) hz = 1;
            end
            if (m_stm && m_first == ldq[i].rd && age <= 1) eh = 1;
        end
        e_se = eh && !flush;
        e_sd = ((hz && !hold) || e_se) && !flush;
        e_bx = e_sd && !e_se;
        e_bm = e_se;
    endfunction

    function automatic void model_update();
        last_adv = d_valid && !e_sd && !hold && !flush;
        if (last_adv && is_load) ldq.push_back('{cyc + 1, ld_dst, (ld_size != 2'b10)});
        m_stm = !flush && ((m_stm && (e_se || hold)) || (last_adv && is_multi && is_stm));
        if (last_adv && is_multi && is_stm) m_first = first;
        cyc++;
        while (ldq.size() > 0 && (cyc - ldq[0].t) > 3) void'(ldq.pop_front());
    endfunction

    // ---------------- stimulus helpers ----------------
    task automatic put_nop();
        d_valid = 1; ra_use = 0; rb_use = 0; rc_use = 0; is_load = 0; is_multi = 0;
        is_stm = 0; ra = 0; rb = 0; rc = 0; ld_dst = 0; ld_size = 2'b10; base = 0; first = 0;
    endtask

    task automatic put_load(input logic [3:0] rd, input logic [1:0] sz);
        put_nop(); is_load = 1; ld_dst = rd; ld_size = sz; ra = 4'd15; ra_use = 1;
    endtask

    task automatic put_alu(input logic [3:0] a, input bit ua, input logic [3:0] b, input bit ub);
        put_nop(); ra = a; ra_use = ua; rb = b; rb_use = ub;
    endtask

    task automatic put_cport(input logic [3:0] c);
        put_nop(); rc = c; rc_use = 1; ra = 4'd14; ra_use = 1;
    endtask

    task automatic put_multi(input bit st, input logic [3:0] b, input logic [3:0] f);
        put_nop(); is_multi = 1; is_stm = st; base = b; first = f;
    endtask

    // One cycle: compare outputs with the model, then advance across the edge.
    task automatic tick(input string req);
        #1;
        model_eval();
        total++;
        if (sd !== e_sd || se !== e_se || bx !== e_bx || bm !== e_bm) begin
            bad++;
            $display("FAIL %s cycle %0d: got sd=%b se=%b bx=%b bm=%b expected sd=%b se=%b bx=%b bm=%b",
                     req, cyc, sd, se, bx, bm, e_sd, e_se, e_bx, e_bm);
        end
        if (se === 1'b1) seen_se = 1;
        if (bx === 1'b1) seen_bx = 1;
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    // Keep the current descriptor in Decode until it is taken; count stall cycles.
    task automatic issue(input string req, output int n);
        n = 0;
        forever begin
            tick(req);
            if (last_adv || n > 8) break;
            n++;
        end
    endtask

    task automatic expect_stalls(input string req, input int exp);
        int n;
        issue(req, n);
        total++;
        if (n != exp) begin
            bad++;
            $display("FAIL %s stall cycles: got %0d expected %0d", req, n, exp);
        end
    endtask

    task automatic go(input string req);
        int n;
        issue(req, n);
    endtask

    task automatic drain();
        for (int k = 0; k < 3; k++) begin
            put_nop(); go("drain");
        end
    endtask

    task automatic check_bit(input string req, input bit got, input bit exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        rst_n = 0; hold = 0; flush = 0;
        put_nop(); d_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: no tracked load after reset
        put_alu(4'd0, 1, 4'd1, 1);
        expect_stalls("R1", 0);

        // R2: word load, A then B consumer
        put_load(4'd1, 2'b10); go("R2");
        seen_bx = 0;
        put_alu(4'd1, 1, 4'd2, 1); expect_stalls("R2", 1);
        check_bit("R9 bubble_ex on decode stall", seen_bx, 1);
        drain();
        put_load(4'd2, 2'b10); go("R2");
        put_alu(4'd5, 1, 4'd2, 1); expect_stalls("R2", 1);
        drain();

        // R3: narrow loads
        put_load(4'd3, 2'b00); go("R3");
        put_alu(4'd3, 1, 4'd0, 0); expect_stalls("R3", 2);
        drain();
        put_load(4'd3, 2'b01); go("R3");
        put_nop(); go("R3");
        put_alu(4'd3, 1, 4'd0, 0); expect_stalls("R3", 1);
        drain();
        put_load(4'd3, 2'b10); go("R3");
        put_nop(); go("R3");
        put_alu(4'd3, 1, 4'd0, 0); expect_stalls("R3", 0);
        drain();

        // R4: second reader after the stall
        put_load(4'd4, 2'b00); go("R4");
        put_alu(4'd4, 1, 4'd0, 0); expect_stalls("R4", 2);
        put_alu(4'd0, 0, 4'd4, 1); expect_stalls("R4", 0);
        drain();

        // R5: C-port consumers
        put_load(4'd5, 2'b00); go("R5");
        put_cport(4'd5); expect_stalls("R5", 1);
        drain();
        put_load(4'd5, 2'b10); go("R5");
        put_nop(); go("R5");
        put_cport(4'd5); expect_stalls("R5", 0);
        drain();

        // R6: multi-cycle instruction between load and consumer
        put_load(4'd6, 2'b00); go("R6");
        put_alu(4'd7, 1, 4'd8, 1); go("R6");
        put_alu(4'd6, 1, 4'd0, 0);
        hold = 1; tick("R6"); hold = 0;
        expect_stalls("R6", 0);
        drain();

        // R7: multiple transfer base interlock
        put_load(4'd9, 2'b10); go("R7");
        put_multi(0, 4'd9, 4'd0); expect_stalls("R7", 1);
        drain();
        put_load(4'd9, 2'b00); go("R7");
        put_multi(1, 4'd9, 4'd1); expect_stalls("R7", 2);
        drain();

        // R8: store-multiple first stored register, second-cycle interlock
        put_load(4'd10, 2'b10); go("R8");
        put_multi(1, 4'd11, 4'd10); expect_stalls("R8", 0);
        seen_se = 0;
        put_nop(); expect_stalls("R8", 1);
        check_bit("R8 execute stall seen", seen_se, 1);
        drain();
        put_load(4'd10, 2'b10); go("R8");
        put_multi(1, 4'd11, 4'd12); go("R8");
        seen_se = 0;
        put_nop(); expect_stalls("R8", 0);
        check_bit("R8 no execute stall on other register", seen_se, 0);
        drain();

        // R10: flush cancels interlocks and drops the Decode instruction
        put_load(4'd7, 2'b10); go("R10");
        put_alu(4'd7, 1, 4'd0, 0);
        flush = 1; tick("R10"); flush = 0;
        expect_stalls("R10", 0);
        drain();
        put_load(4'd8, 2'b00);
        flush = 1; tick("R10"); flush = 0;
        put_alu(4'd8, 1, 4'd0, 0); expect_stalls("R10", 0);
        drain();
        put_load(4'd3, 2'b10); go("R10");
        put_multi(1, 4'd11, 4'd3); go("R10");
        seen_se = 0;
        put_nop();
        flush = 1; tick("R10"); flush = 0;
        expect_stalls("R10", 0);
        check_bit("R10 store-multiple dropped by flush", seen_se, 0);
        drain();

        // R11: unused ports and unrelated registers
        put_load(4'd6, 2'b00); go("R11");
        put_alu(4'd6, 0, 4'd6, 0); rc = 4'd6; expect_stalls("R11", 0);
        drain();
        put_load(4'd6, 2'b10); go("R11");
        put_alu(4'd1, 1, 4'd2, 1); expect_stalls("R11", 0);
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule